// File: doc/BRIEF.md
# Serial Control and Fault Status Port for a Six-Channel Gate Driver

This block is the serial slave port of a multi-channel low-side gate driver. A host uses a four-wire serial bus (clock, data in, data out, active-low select) to write the gate-control word, a fault configuration word for each channel and the fault mask. The block hands these register values to the channel logic. Each frame also returns a status word built from the per-channel fault flags that the channel logic supplies.

The serial pins are sampled with the block's own system clock. Each pin goes through a two-stage synchronizer, and edges are found in the clock domain. A frame is 16 bits long and is sent most significant bit first: a 4-bit register address comes first, then 12 data bits. Shifted data reaches a register only when select is released and exactly 16 bits have been clocked. One write to the gate-control word changes every channel at once. While select is high, the data-out driver is switched off. The block gives an enable pin for the pad's tri-state driver.

Top module: `spi_ctl_if`

## Requirements
- R1: After reset, gate_ctl, fault_mask and every fault configuration field are zero, spi_so_en is low, and the reset-latch bit (status bit 15) is set.
- R2: Data in is sampled on rising serial-clock edges while select is low, most significant bit first. Frame bits 15:12 are the address and bits 11:0 are the data.
- R3: A register keeps its old value until select is released. Nothing changes while a frame is still open, even after all 16 bits have been shifted.
- R4: A valid frame to address 0 loads gate_ctl from data bits 5:0. All six channel bits change in the same clock cycle.
- R5: A valid frame to address k (1 to 6) loads the configuration field of channel k-1 from data bits 7:0. The other channels' fields are left as they are.
- R6: A valid frame to address 7 loads fault_mask from data bits 5:0.
- R7: A valid frame to address 8 through 15 changes no register.
- R8: A frame with a bit count other than 16 changes no register when select is released.
- R9: spi_so_en is low while select is high and high while select is low.
- R10: During a frame, data out shifts out a status word most significant bit first, and it changes only after falling serial-clock edges. The word is captured when select falls. Bit 15 is the reset latch. Bit 14 is the OR of fault_in AND NOT fault_mask. Bits 5:0 are fault_in. All other bits are 0.
- R11: The reset latch is cleared when a valid 16-bit frame completes, whatever its address. A frame with a bad length leaves the latch as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_csn | input | 1 | Active-low select |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out |
| spi_so_en | output | 1 | Output enable for the data-out pad driver |
| fault_in | input | 6 | Per-channel fault flags from the channel logic |
| gate_ctl | output | 6 | Serial gate-control bit for each channel |
| fault_cfg | output | 48 | Configuration fields, 8 bits per channel, channel 0 in the low bits |
| fault_mask | output | 6 | Per-channel fault mask |

## Verification
Every pin passes through two synchronizer flops, and one more register acts on the detected edge. A pin change therefore shows at the outputs on the third rising clock edge after it. This covers register updates after select rises, the status capture after select falls, and each data-out shift after a falling serial clock. The bench drives each serial level for eight system clocks and samples at falling clock edges at least eight cycles after each change, so every sample falls well past the three-cycle latency. Data out is sampled just before each rising serial clock, which is when a host would sample it. It is sampled again at the end of the high phase to confirm it has not moved. Register outputs are checked once just before select is released and again eight cycles after it.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  // Register addresses (decoded by the register bank)
  localparam int unsigned ADR_GATE     = 0;
  localparam int unsigned ADR_CFG_BASE = 1;
  // Status word bit positions
  localparam int unsigned ST_LATCH  = 15;
  localparam int unsigned ST_GLOBAL = 14;
endpackage

// File: rtl/spi_ctl_sync.sv
module spi_ctl_sync #(
  parameter int unsigned W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stg1_q;
  logic [W-1:0] stg2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= RST_VAL;
      stg2_q <= RST_VAL;
    end else begin
      stg1_q <= d_async;
      stg2_q <= stg1_q;
    end
  end

  assign d_sync = stg2_q;
endmodule

// File: rtl/spi_ctl_frame.sv
module spi_ctl_frame #(
  parameter int unsigned FRAME_W = 16,
  parameter int unsigned CNT_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sck_s,
  input  logic               csn_s,
  input  logic               si_s,
  input  logic [FRAME_W-1:0] status_word,
  output logic               so_bit,
  output logic               so_en,
  output logic               wr_stb,
  output logic [FRAME_W-1:0] wr_word,
  output logic [CNT_W-1:0]   bit_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic               sck_d_q, csn_d_q, so_en_q;
  logic [FRAME_W-1:0] sh_in_q, sh_in_n;
  logic [FRAME_W-1:0] sh_out_q, sh_out_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic               sck_rise, sck_fall, csn_fall, csn_rise;

  always_comb begin
    sck_rise = sck_s & ~sck_d_q & ~csn_s;
    sck_fall = ~sck_s & sck_d_q & ~csn_s;
    csn_fall = ~csn_s & csn_d_q;
    csn_rise = csn_s & ~csn_d_q;

    sh_in_n = sh_in_q;
    if (sck_rise) sh_in_n = {sh_in_q[FRAME_W-2:0], si_s};

    sh_out_n = sh_out_q;
    if (csn_fall)      sh_out_n = status_word;
    else if (sck_fall) sh_out_n = {sh_out_q[FRAME_W-2:0], 1'b0};

    cnt_n = cnt_q;
    if (csn_fall)                         cnt_n = '0;
    else if (sck_rise && cnt_q != CNT_MAX) cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d_q  <= 1'b0;
      csn_d_q  <= 1'b1;
      so_en_q  <= 1'b0;
      sh_in_q  <= '0;
      sh_out_q <= '0;
      cnt_q    <= '0;
    end else begin
      sck_d_q  <= sck_s;
      csn_d_q  <= csn_s;
      so_en_q  <= ~csn_s;
      sh_in_q  <= sh_in_n;
      sh_out_q <= sh_out_n;
      cnt_q    <= cnt_n;
    end
  end

  assign so_bit  = sh_out_q[FRAME_W-1];
  assign so_en   = so_en_q;
  assign wr_stb  = csn_rise && (cnt_q == CNT_FULL);
  assign wr_word = sh_in_q;
  assign bit_cnt = cnt_q;
endmodule

// File: rtl/spi_ctl_regs.sv
module spi_ctl_regs
  import spi_ctl_pkg::*;
#(
  parameter int unsigned NCH    = 6,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 12,
  parameter int unsigned CFG_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_stb,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  output logic [NCH-1:0]       gate_ctl,
  output logic [NCH*CFG_W-1:0] fault_cfg,
  output logic [NCH-1:0]       fault_mask,
  output logic                 rst_latch
);
  localparam logic [ADDR_W-1:0] A_GATE = ADDR_W'(ADR_GATE);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(ADR_CFG_BASE + NCH);

  logic           gate_we, mask_we;
  logic [NCH-1:0] gate_q, gate_n, mask_q, mask_n;
  logic           latch_q, latch_n;

  always_comb begin
    gate_we = wr_stb && (wr_addr == A_GATE);
    mask_we = wr_stb && (wr_addr == A_MASK);
    gate_n  = gate_we ? wr_data[NCH-1:0] : gate_q;
    mask_n  = mask_we ? wr_data[NCH-1:0] : mask_q;
    latch_n = wr_stb ? 1'b0 : latch_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q  <= '0;
      mask_q  <= '0;
      latch_q <= 1'b1;
    end else begin
      gate_q  <= gate_n;
      mask_q  <= mask_n;
      latch_q <= latch_n;
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_cfg
    logic             cfg_we;
    logic [CFG_W-1:0] cfg_q, cfg_n;

    always_comb begin
      cfg_we = wr_stb && (wr_addr == ADDR_W'(ADR_CFG_BASE + ch));
      cfg_n  = cfg_we ? wr_data[CFG_W-1:0] : cfg_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q <= '0;
      else        cfg_q <= cfg_n;
    end

    assign fault_cfg[ch*CFG_W +: CFG_W] = cfg_q;
  end

  assign gate_ctl   = gate_q;
  assign fault_mask = mask_q;
  assign rst_latch  = latch_q;
endmodule

// File: rtl/spi_ctl_if.sv
module spi_ctl_if
  import spi_ctl_pkg::*;
#(
  parameter int unsigned NCH     = 6,
  parameter int unsigned FRAME_W = 16,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned CFG_W   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 spi_sck,
  input  logic                 spi_csn,
  input  logic                 spi_si,
  output logic                 spi_so,
  output logic                 spi_so_en,
  input  logic [NCH-1:0]       fault_in,
  output logic [NCH-1:0]       gate_ctl,
  output logic [NCH*CFG_W-1:0] fault_cfg,
  output logic [NCH-1:0]       fault_mask
);
  localparam int unsigned DATA_W = FRAME_W - ADDR_W;
  localparam int unsigned CNT_W  = $clog2(FRAME_W + 2);

  logic [1:0]         rst_pipe_q;
  logic               rst_n_s;
  logic [2:0]         pins_s;
  logic               sck_s, csn_s, si_s;
  logic [FRAME_W-1:0] status_word, wr_word;
  logic               wr_stb, rst_latch;
  logic [ADDR_W-1:0]  wr_addr;
  logic [CNT_W-1:0]   bit_cnt;

  // Reset asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  spi_ctl_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .d_async ({spi_sck, spi_csn, spi_si}),
    .d_sync  (pins_s)
  );
  assign {sck_s, csn_s, si_s} = pins_s;

  always_comb begin
    status_word            = '0;
    status_word[ST_LATCH]  = rst_latch;
    status_word[ST_GLOBAL] = |(fault_in & ~fault_mask);
    status_word[NCH-1:0]   = fault_in;
  end

  spi_ctl_frame #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_frame (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .sck_s       (sck_s),
    .csn_s       (csn_s),
    .si_s        (si_s),
    .status_word (status_word),
    .so_bit      (spi_so),
    .so_en       (spi_so_en),
    .wr_stb      (wr_stb),
    .wr_word     (wr_word),
    .bit_cnt     (bit_cnt)
  );

  assign wr_addr = wr_word[FRAME_W-1 -: ADDR_W];

  spi_ctl_regs #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_W(CFG_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .wr_stb     (wr_stb),
    .wr_addr    (wr_addr),
    .wr_data    (wr_word[DATA_W-1:0]),
    .gate_ctl   (gate_ctl),
    .fault_cfg  (fault_cfg),
    .fault_mask (fault_mask),
    .rst_latch  (rst_latch)
  );
endmodule

// File: rtl/spi_ctl_if_chk.sv
module spi_ctl_if_chk #(
  parameter int unsigned NCH     = 6,
  parameter int unsigned FRAME_W = 16,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned CFG_W   = 8,
  parameter int unsigned CNT_W   = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 csn_s,
  input logic [CNT_W-1:0]     bit_cnt,
  input logic                 wr_stb,
  input logic [ADDR_W-1:0]    wr_addr,
  input logic [NCH-1:0]       gate_ctl,
  input logic [NCH*CFG_W-1:0] fault_cfg,
  input logic [NCH-1:0]       fault_mask,
  input logic                 rst_latch,
  input logic                 so_en
);
  localparam logic [ADDR_W-1:0] A_HIGH = ADDR_W'(NCH + 2);
  localparam logic [CNT_W-1:0]  N_FULL = CNT_W'(FRAME_W);

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(csn_s) |=> (bit_cnt == '0)) else $error("cnt"); // R2
  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(gate_ctl)) else $error("gate"); // R3
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(fault_cfg)) else $error("cfg"); // R5
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(fault_mask)) else $error("mask"); // R6
  AST_HIGH_ADDR_NOWR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_addr >= A_HIGH) |=> ($stable(gate_ctl) && $stable(fault_cfg) && $stable(fault_mask))) else $error("hiaddr"); // R7
  AST_BAD_LEN_NOWR: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(csn_s) && bit_cnt != N_FULL) |=> ($stable(gate_ctl) && $stable(fault_cfg) && $stable(fault_mask) && $stable(rst_latch))) else $error("badlen"); // R8
  AST_SO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (csn_s && $past(csn_s)) |-> !so_en) else $error("so_en"); // R9
  AST_LATCH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !rst_latch) else $error("latch"); // R11
endmodule

bind spi_ctl_if spi_ctl_if_chk #(
  .NCH(NCH), .FRAME_W(FRAME_W), .ADDR_W(ADDR_W), .CFG_W(CFG_W), .CNT_W(CNT_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n_s),
  .csn_s      (csn_s),
  .bit_cnt    (bit_cnt),
  .wr_stb     (wr_stb),
  .wr_addr    (wr_addr),
  .gate_ctl   (gate_ctl),
  .fault_cfg  (fault_cfg),
  .fault_mask (fault_mask),
  .rst_latch  (rst_latch),
  .so_en      (spi_so_en)
);

// File: tb/spi_ctl_if_tb_top.sv
module spi_ctl_if_tb_top;
  localparam int NCH = 6;
  localparam int CFG_W = 8;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sck = 1'b0, spi_csn = 1'b1, spi_si = 1'b0;
  logic spi_so, spi_so_en;
  logic [NCH-1:0] fault_in = '0;
  logic [NCH-1:0] gate_ctl, fault_mask;
  logic [NCH*CFG_W-1:0] fault_cfg;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model
  logic [NCH-1:0]       m_gate = '0, m_mask = '0;
  logic [NCH*CFG_W-1:0] m_cfg = '0;
  logic                 m_latch = 1'b1;
  logic [15:0]          rx;

  always #2 clk = ~clk;

  spi_ctl_if dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_csn(spi_csn), .spi_si(spi_si),
    .spi_so(spi_so), .spi_so_en(spi_so_en), .fault_in(fault_in),
    .gate_ctl(gate_ctl), .fault_cfg(fault_cfg), .fault_mask(fault_mask)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_status(logic latch, logic [NCH-1:0] f, logic [NCH-1:0] m);
    logic [15:0] s = '0;
    s[15] = latch;
    s[14] = |(f & ~m);
    s[NCH-1:0] = f;
    return s;
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_begin();
    @(negedge clk);
    spi_csn = 1'b0;
    wait_clk(HALF);
    chk("R9 so_en low-select", {63'b0, spi_so_en}, 64'd1);
  endtask

  task automatic spi_bits(input logic [15:0] tx, input int n);
    rx = '0;
    for (int i = 0; i < n; i++) begin
      logic b;
      spi_si = (i < 16) ? tx[15-i] : 1'b0;
      wait_clk(2);
      b = spi_so;
      if (i < 16) rx = {rx[14:0], b};
      spi_sck = 1'b1;
      wait_clk(HALF);
      if (i < 16) chk("R10 so holds while sck high", {63'b0, spi_so}, {63'b0, b});
      spi_sck = 1'b0;
      wait_clk(HALF);
    end
  endtask

  task automatic spi_end();
    spi_csn = 1'b1;
    wait_clk(HALF);
    chk("R9 so_en high-select", {63'b0, spi_so_en}, 64'd0);
  endtask

  task automatic model_commit(input logic [15:0] w, input int n);
    int a = int'(w[15:12]);
    if (n != 16) return;
    m_latch = 1'b0;
    if (a == 0) m_gate = w[NCH-1:0];
    else if (a >= 1 && a <= NCH) m_cfg[(a-1)*CFG_W +: CFG_W] = w[CFG_W-1:0];
    else if (a == NCH + 1) m_mask = w[NCH-1:0];
  endtask

  task automatic check_regs(input string req);
    chk({req, " gate_ctl"}, {58'b0, gate_ctl}, {58'b0, m_gate});
    chk({req, " fault_cfg"}, {16'b0, fault_cfg}, {16'b0, m_cfg});
    chk({req, " fault_mask"}, {58'b0, fault_mask}, {58'b0, m_mask});
  endtask

  // full frame with status and register checks against the model
  task automatic frame(input logic [15:0] tx, input int n, input string req);
    logic [15:0] es = exp_status(m_latch, fault_in, m_mask);
    logic [15:0] ecmp = (n < 16) ? (es >> (16 - n)) : es;
    spi_begin();
    spi_bits(tx, n);
    spi_end();
    chk("R10 status word", {48'b0, rx}, {48'b0, ecmp});
    model_commit(tx, n);
    check_regs(req);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h1A2B3C4D));
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(6);
    // R1 reset state
    check_regs("R1 reset");
    chk("R1 so_en reset", {63'b0, spi_so_en}, 64'd0);

    // R8: short frame to gate register, latch must stay set (R11)
    fault_in = 6'b100101;
    frame(16'h003F, 15, "R8 short frame");
    // R3 and R4: 16 bits in, select still low -> no change yet
    fault_in = 6'b000011;
    spi_begin();
    spi_bits(16'h002A, 16);
    wait_clk(HALF);
    check_regs("R3 before release");
    spi_end();
    chk("R1 R11 latch still set after bad frame", {63'b0, rx[15]}, 64'd1);
    model_commit(16'h002A, 16);
    check_regs("R4 gate write");
    // R11: latch now cleared
    frame(16'h10A5, 16, "R5 cfg ch0");
    chk("R11 latch cleared", {63'b0, rx[15]}, 64'd0);
    // R6 mask then R10 global bit masking
    frame(16'h7003, 16, "R6 mask write");
    fault_in = 6'b000011;
    frame(16'h0000, 16, "R4 gate clear");
    chk("R10 global masked", {63'b0, rx[14]}, 64'd0);
    fault_in = 6'b100000;
    frame(16'h6F7E, 16, "R5 cfg ch5");
    chk("R10 global set", {63'b0, rx[14]}, 64'd1);
    // R7 high addresses; R8 long frame; R2 msb-first address decode
    frame(16'h8FFF, 16, "R7 addr 8");
    frame(16'hFFFF, 16, "R7 addr 15");
    frame(16'h0015, 17, "R8 long frame");
    frame(16'h3C81, 16, "R2 R5 cfg ch2");

    for (int it = 0; it < 50; it++) begin
      logic [15:0] w = 16'($urandom);
      int r = int'($urandom % 8);
      int n = (r == 0) ? 15 : (r == 1) ? 17 : 16;
      fault_in = NCH'($urandom);
      frame(w, n, "R2 R4 R5 R6 R7 R8 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule